// File: doc/BRIEF.md
# Nibble-Decomposed 8x8 Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product, purely combinationally. It has no clock and no state: the product follows the operands after the logic settles. Each operand is split into a low nibble and a high nibble. Four 4x4 array multipliers then form the four cross products. Each array uses one AND gate per bit pair and a grid of full-adder cells.

The four 8-bit cross products overlap in nibble-wide columns. The lowest nibble of the result needs no addition. Each of the two middle nibbles is the sum of three nibble operands. A row of full adders first reduces these three operands to a sum vector and a carry vector. A 4-bit carry-lookahead adder then adds the two vectors, with the carry vector shifted up one place. Each middle stage passes two carries to the stage above it. One enters the free bit-0 slot of the shifted carry vector. The other enters the lookahead adder's carry-in. No carry is dropped. The top nibble adds those two carries to the high nibble of the last cross product.

Top module: `nibble_mult8`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `product` equals opA * opB as an unsigned 16-bit value.
- R2: Each internal 4x4 cross product equals the product of its two nibbles, so the result equals that cross product at its nibble weight whenever only one nibble of each operand is nonzero. The cross products are low*low at weight 0, highA*lowB and lowA*highB at weight 4, and high*high at weight 8.
- R3: `product[3:0]` equals the low 4 bits of opA[3:0] * opB[3:0].
- R4: `product[7:4]` equals the low 4 bits of the sum of three nibbles: bits 7:4 of the low*low product, and bits 3:0 of the two mixed products.
- R5: `product[11:8]` equals the low 4 bits of the sum of four terms: bits 7:4 of both mixed products, bits 3:0 of the high*high product, and the carry value out of the R4 sum.
- R6: `product[15:12]` equals bits 7:4 of the high*high product plus the carry value out of the R5 sum. No carry is lost, so 255*255 gives 16'hFE01.
- R7: A zero in either operand gives a zero product.
- R8: An operand equal to 1 passes the other operand, zero-extended, to `product`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | Unsigned multiplicand |
| opB | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product opA * opB |

## Verification
The block holds no state, so a wrong internal value shows on `product` for the same operand pair that excites it, as soon as the logic settles. A fault in a sub-multiplier cell or in a carry-save bit shows up in the nibble that the faulty path feeds. A lost or doubled stage carry shows up one nibble higher. This is why the bench checks each result nibble on its own, against its own arithmetic sum, for every one of the 65536 operand pairs.

// File: rtl/nibmul_pkg.sv
package nibmul_pkg;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 2 * NIB_W;
  localparam int PROD_W = 2 * OP_W;

  typedef logic [NIB_W-1:0]   nibble_t;
  typedef logic [OP_W-1:0]    subprod_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/nib_array_mult.sv
// W x W unsigned array multiplier: one AND per bit pair, rows of full-adder cells.
module nib_array_mult #(
  parameter int W = 4
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  logic [W:0] rowVal [0:W-1];

  assign rowVal[0] = {1'b0, x & {W{y[0]}}};
  assign p[0]      = rowVal[0][0];

  for (genvar i = 1; i < W; i++) begin : gRow
    logic [W-1:0] andRow;
    logic [W-1:0] sumRow;
    logic [W:0]   carryChain;

    assign andRow        = x & {W{y[i]}};
    assign carryChain[0] = 1'b0;

    for (genvar j = 0; j < W; j++) begin : gCell
      fa_cell uCell (
        .a  (rowVal[i-1][j+1]),
        .b  (andRow[j]),
        .ci (carryChain[j]),
        .s  (sumRow[j]),
        .co (carryChain[j+1])
      );
    end

    assign rowVal[i] = {carryChain[W], sumRow};
    assign p[i]      = rowVal[i][0];
  end

  assign p[2*W-1:W] = rowVal[W-1][W:1];
endmodule

// File: rtl/nib_cla.sv
// W-bit carry-lookahead adder: every carry is a flat sum of generate/propagate terms.
module nib_cla #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign gen  = x & y;
  assign prop = x ^ y;

  always_comb begin
    for (int k = 0; k <= W; k++) begin
      logic term;
      logic acc;
      term = cin;
      for (int j = 0; j < k; j++) term = term & prop[j];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = gen[j];
        for (int m = j + 1; m < k; m++) term = term & prop[m];
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end

  assign sum  = prop ^ carry[W-1:0];
  assign cout = carry[W];
endmodule

// File: rtl/nib_sum3.sv
// Three-operand nibble adder: carry-save row, then lookahead on sum + shifted carry.
// Two incoming carries: one fills the free bit-0 slot, one uses the carry-in.
module nib_sum3 #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic         cInA,
  input  logic         cInB,
  output logic [W-1:0] sum,
  output logic         cOutA,
  output logic         cOutB
);
  logic [W-1:0] saveSum;
  logic [W-1:0] saveCarry;
  logic [W-1:0] shiftedCarry;

  for (genvar i = 0; i < W; i++) begin : gCsa
    fa_cell uCsa (
      .a  (x[i]),
      .b  (y[i]),
      .ci (z[i]),
      .s  (saveSum[i]),
      .co (saveCarry[i])
    );
  end

  assign shiftedCarry = {saveCarry[W-2:0], cInA};
  assign cOutA        = saveCarry[W-1];

  nib_cla #(.W(W)) uCla (
    .x    (saveSum),
    .y    (shiftedCarry),
    .cin  (cInB),
    .sum  (sum),
    .cout (cOutB)
  );
endmodule

// File: rtl/nib_top_add.sv
// Top nibble: x + cInA + cInB with lookahead carries for the in-range bits only.
module nib_top_add #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic         cInA,
  input  logic         cInB,
  output logic [W-1:0] sum
);
  logic [W-1:0] addend;
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] carry;

  assign addend = {{(W-1){1'b0}}, cInA};
  assign gen    = x & addend;
  assign prop   = x ^ addend;

  always_comb begin
    for (int k = 0; k < W; k++) begin
      logic term;
      logic acc;
      term = cInB;
      for (int j = 0; j < k; j++) term = term & prop[j];
      acc = term;
      for (int j = 0; j < k; j++) begin
        term = gen[j];
        for (int m = j + 1; m < k; m++) term = term & prop[m];
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end

  assign sum = prop ^ carry;
endmodule

// File: rtl/nibble_mult8.sv
module nibble_mult8
  import nibmul_pkg::*;
(
  input  logic [7:0]  opA,
  input  logic [7:0]  opB,
  output logic [15:0] product
);
  localparam int N = NIB_W;

  nibble_t  aLo, aHi, bLo, bHi;
  subprod_t pp0, pp1, pp2, pp3;
  nibble_t  midSum, highSum, topSum;
  logic     c1A, c1B, c2A, c2B;

  assign aLo = opA[N-1:0];
  assign aHi = opA[OP_W-1:N];
  assign bLo = opB[N-1:0];
  assign bHi = opB[OP_W-1:N];

  // Four cross products
  nib_array_mult #(.W(N)) uPp0 (.x(aLo), .y(bLo), .p(pp0));
  nib_array_mult #(.W(N)) uPp1 (.x(aHi), .y(bLo), .p(pp1));
  nib_array_mult #(.W(N)) uPp2 (.x(aLo), .y(bHi), .p(pp2));
  nib_array_mult #(.W(N)) uPp3 (.x(aHi), .y(bHi), .p(pp3));

  // Nibble 1: three operands, no incoming carries
  nib_sum3 #(.W(N)) uMid (
    .x(pp0[OP_W-1:N]), .y(pp1[N-1:0]), .z(pp2[N-1:0]),
    .cInA(1'b0), .cInB(1'b0),
    .sum(midSum), .cOutA(c1A), .cOutB(c1B)
  );

  // Nibble 2: three operands plus both carries from nibble 1
  nib_sum3 #(.W(N)) uHigh (
    .x(pp1[OP_W-1:N]), .y(pp2[OP_W-1:N]), .z(pp3[N-1:0]),
    .cInA(c1A), .cInB(c1B),
    .sum(highSum), .cOutA(c2A), .cOutB(c2B)
  );

  // Nibble 3: high*high upper nibble plus both carries from nibble 2
  nib_top_add #(.W(N)) uTop (
    .x(pp3[OP_W-1:N]), .cInA(c2A), .cInB(c2B), .sum(topSum)
  );

  assign product = {topSum, highSum, midSum, pp0[N-1:0]};
endmodule

// File: rtl/nibble_mult8_chk.sv
module nibble_mult8_chk (
  input logic [7:0]  opA,
  input logic [7:0]  opB,
  input logic [15:0] product,
  input logic [7:0]  pp0,
  input logic [7:0]  pp1,
  input logic [7:0]  pp2,
  input logic [7:0]  pp3,
  input logic        c1A,
  input logic        c1B,
  input logic        c2A,
  input logic        c2B
);
  logic [15:0] refProd;
  logic [5:0]  midRef, midGot;
  logic [5:0]  highRef, highGot;

  assign refProd = 16'(opA) * 16'(opB);
  assign midRef  = 6'(pp0[7:4]) + 6'(pp1[3:0]) + 6'(pp2[3:0]);
  assign midGot  = 6'(product[7:4]) + (6'(c1A) << 4) + (6'(c1B) << 4);
  assign highRef = 6'(pp1[7:4]) + 6'(pp2[7:4]) + 6'(pp3[3:0]) + 6'(c1A) + 6'(c1B);
  assign highGot = 6'(product[11:8]) + (6'(c2A) << 4) + (6'(c2B) << 4);

  always_comb begin
    AST_PRODUCT_EXACT: assert (product == refProd) else $error("product mismatch"); // R1
    AST_SUBPRODUCTS: assert (pp0 == 8'(opA[3:0]) * 8'(opB[3:0]) && pp1 == 8'(opA[7:4]) * 8'(opB[3:0])
                             && pp2 == 8'(opA[3:0]) * 8'(opB[7:4]) && pp3 == 8'(opA[7:4]) * 8'(opB[7:4]))
      else $error("cross product mismatch"); // R2
    AST_MID_NIBBLE: assert (midGot == midRef) else $error("nibble 1 sum mismatch"); // R4
    AST_HIGH_NIBBLE: assert (highGot == highRef) else $error("nibble 2 sum mismatch"); // R5
    AST_TOP_NIBBLE: assert (product[15:12] == 4'(pp3[7:4] + 4'(c2A) + 4'(c2B))) else $error("top nibble mismatch"); // R6
    AST_ZERO_OPERAND: assert (!(opA == 8'd0 || opB == 8'd0) || product == 16'd0) else $error("zero operand"); // R7
  end
endmodule

bind nibble_mult8 nibble_mult8_chk uChk (.*);

// File: tb/nibble_mult8_test.sv
module nibble_mult8_test;
  logic        clk = 1'b0;
  logic [7:0]  opA = 8'd0;
  logic [7:0]  opB = 8'd0;
  logic [15:0] product;
  int          checks = 0;
  int          fails = 0;
  int          cycles = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  nibble_mult8 uut (.opA(opA), .opB(opB), .product(product));

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, opA, opB, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int ll, hl, lh, hh, full, s1, s2, s3;
        @(posedge clk);
        opA = 8'(a);
        opB = 8'(b);
        @(negedge clk);
        ll   = (a % 16) * (b % 16);
        hl   = (a / 16) * (b % 16);
        lh   = (a % 16) * (b / 16);
        hh   = (a / 16) * (b / 16);
        full = a * b;
        s1 = (ll / 16) + (hl % 16) + (lh % 16);
        s2 = (hl / 16) + (lh / 16) + (hh % 16) + s1 / 16;
        s3 = (hh / 16) + s2 / 16;
        // R1: full product
        check(product == 16'(full), "R1", int'(product), full);
        // R3: low nibble straight from low*low
        check(int'(product[3:0]) == ll % 16, "R3", int'(product[3:0]), ll % 16);
        // R4: nibble 1 three-operand sum
        check(int'(product[7:4]) == s1 % 16, "R4", int'(product[7:4]), s1 % 16);
        // R5: nibble 2 sum with carries from nibble 1
        check(int'(product[11:8]) == s2 % 16, "R5", int'(product[11:8]), s2 % 16);
        // R6: top nibble with carries from nibble 2, nothing lost
        check(int'(product[15:12]) == s3, "R6", int'(product[15:12]), s3);
        // R2: isolated cross products at their weights
        if (a < 16 && b < 16) check(int'(product) == ll, "R2 low*low", int'(product), ll);
        if (a % 16 == 0 && b < 16) check(int'(product) == hl * 16, "R2 highA*lowB", int'(product), hl * 16);
        if (a < 16 && b % 16 == 0) check(int'(product) == lh * 16, "R2 lowA*highB", int'(product), lh * 16);
        if (a % 16 == 0 && b % 16 == 0) check(int'(product) == hh * 256, "R2 high*high", int'(product), hh * 256);
        // R7: zero operand
        if (a == 0 || b == 0) check(product == 16'd0, "R7", int'(product), 0);
        // R8: unit operand passes the other through
        if (a == 1) check(int'(product) == b, "R8", int'(product), b);
        if (b == 1) check(int'(product) == a, "R8", int'(product), a);
        // R6: corner with the largest carry traffic
        if (a == 255 && b == 255) check(product == 16'hFE01, "R6 max", int'(product), 16'hFE01);
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule